// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the byte-wide register file that sits between a host processor and a small 10/100 Ethernet MAC. It decodes three registers on a 2-bit address: network control at 0x0, network status at 0x1 and transmit control at 0x2. The host reaches them through a plain chip-select, write-enable, address and data port. Reads are combinational from the address. Any side effect of a read or a write takes place at the rising clock edge of the cycle in which `host_cs` is high.

The MAC datapath and the PHY drive event and level inputs: link, speed, duplex, receive overflow, wakeup and transmit completion. The bank turns these into read-only bits and sticky flags. In the other direction it drives the MAC's configuration pins: loopback mode, forced collision, duplex, PHY select, wakeup enable, the per-slot CRC and pad suppression bits, the jabber and collision policy bits, and the transmit request.

A software reset is started by writing 1 to the reset bit of the control register. It then runs for a fixed number of clock cycles, set by a parameter sized to 10 µs of the system clock. While it runs, every register bit except PHY select, wakeup enable and wakeup status is held at its default value.

Top module: `emac_regbank`

## Requirements
- R1: After hardware reset (`rst_n` low) all three registers read 0x00, all configuration outputs are 0 and `sw_reset_o` is 0 (internal PHY selected with `phy_duplex` low).
- R2: Status bits 0 (link OK, from `phy_link_ok`), 1 (speed, 1 = 10 Mbps, 0 = 100 Mbps, from `phy_speed_10`) and 2 (receive overflow, from `rx_overflow`) show their inputs directly. Host writes do not change them.
- R3: Status bits 3 and 4 are set by a pulse on `tx_done_slot1` and `tx_done_slot2` respectively. They stay set until any read of the status register, after which both read 0.
- R4: Writing the status register clears each of bits 3, 4 and 5 whose written value is 1. Bits written as 0 keep their value.
- R5: When a set event and a host clear reach the same flag in the same cycle, the flag ends up set.
- R6: Status bit 5 (wakeup) is set by `wake_event` only while control bit 5 (wakeup enable, output `wake_en`) is 1. Writing 0 to control bit 5 clears status bit 5.
- R7: Control bits 3:2 hold the loopback mode, driven on `loopback_mode`: 00 normal, 01 MAC loopback, 10 reserved, 11 internal-PHY 100M digital loopback. Control bit 6 holds force-collision, driven on `force_col`.
- R8: Control bit 4 selects the external PHY (`ext_phy_sel`). Control bit 1 (duplex, driven on `full_duplex`) reads `phy_duplex` while the internal PHY is selected. A write stores bit 1 only when that write leaves bit 4 set, and the stored value is then what reads back.
- R9: Bit 7 of every register reads 0 and ignores writes. Address 0x3 reads 0x00, and writes to it change nothing.
- R10: Transmit-control bits 1..6 are stored as written and driven on `crc_dis_slot1`, `pad_dis_slot1`, `crc_dis_slot2`, `pad_dis_slot2`, `excol_retry` and `jabber_dis` respectively.
- R11: Transmit-control bit 0 (`tx_req`) is set by writing 1 and ignores a written 0. A `tx_done` pulse clears it, unless the same cycle writes 1 to it.
- R12: Writing 1 to control bit 0 starts a software reset that lasts RST_CYCLES cycles. During it, control bit 0 reads 1 and `sw_reset_o` is 1. Afterwards both return to 0. A second start while one is running is ignored.
- R13: While the software reset runs, every bit except control bits 4 and 5 and status bit 5 is held at 0, and host writes to those bits have no effect. Control bits 4 and 5 and status bit 5 keep their values through the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| phy_link_ok | input | 1 | Link status from the PHY |
| phy_speed_10 | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| phy_duplex | input | 1 | Duplex reported by the internal PHY |
| rx_overflow | input | 1 | Receive FIFO overflow level |
| wake_event | input | 1 | Wakeup detector pulse |
| tx_done_slot1 | input | 1 | Packet slot 1 finished transmitting |
| tx_done_slot2 | input | 1 | Packet slot 2 finished transmitting |
| tx_done | input | 1 | Current frame sent completely |
| sw_reset_o | output | 1 | Software reset in progress |
| loopback_mode | output | 2 | Loopback selection |
| force_col | output | 1 | Force collisions (test) |
| full_duplex | output | 1 | Effective duplex mode |
| ext_phy_sel | output | 1 | External PHY selected |
| wake_en | output | 1 | Wakeup function enabled |
| tx_req | output | 1 | Transmit request |
| crc_dis_slot1 | output | 1 | Suppress CRC append, slot 1 |
| pad_dis_slot1 | output | 1 | Suppress padding, slot 1 |
| crc_dis_slot2 | output | 1 | Suppress CRC append, slot 2 |
| pad_dis_slot2 | output | 1 | Suppress padding, slot 2 |
| excol_retry | output | 1 | 1 = keep retrying after more than 15 collisions, 0 = abort |
| jabber_dis | output | 1 | Disable the 2048-byte jabber timer |

## Verification
The assertions assume that `rst_n` is synchronous and that all inputs hold known values after reset. They also assume that the host makes at most one access per cycle, so a read and a write never act on the flags together. The event inputs are treated as single-cycle pulses, and the properties that relate an event to the next state rely on the inputs being stable around the clock edge.

The bench drives every input on the falling edge and holds it for exactly one cycle. It issues host accesses through tasks that return the strobe to idle between operations. It raises an event together with a clear only in the one deliberate collision case.

// File: rtl/emac_regs_pkg.sv
package emac_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_TXC  = 2'd2;

  // control register bit positions
  localparam int C_SWRST = 0;
  localparam int C_FDX   = 1;
  localparam int C_LB_LO = 2;
  localparam int C_LB_HI = 3;
  localparam int C_EXT   = 4;
  localparam int C_WEN   = 5;
  localparam int C_FCOL  = 6;

  // status register bit positions
  localparam int S_LINK  = 0;
  localparam int S_SPD   = 1;
  localparam int S_OVF   = 2;
  localparam int S_TX1   = 3;
  localparam int S_TX2   = 4;
  localparam int S_WAKE  = 5;

  // transmit control bit positions
  localparam int T_REQ   = 0;
  localparam int T_CFG_LO = 1;
  localparam int T_CFG_HI = 6;
  localparam int T_CFG_W = T_CFG_HI - T_CFG_LO + 1;

  // sticky flag indices
  localparam int F_TX1  = 0;
  localparam int F_TX2  = 1;
  localparam int F_WAKE = 2;
  localparam int NFLAG  = 3;
endpackage

// File: rtl/emac_rst_timer.sv
module emac_rst_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  p_start_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt_q == CW'(CYCLES - 1));
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q < CW'(CYCLES));
  p_restart_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/emac_sticky_flag.sv
module emac_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> q == $past(q));
endmodule

// File: rtl/emac_regbank.sv
module emac_regbank
  import emac_regs_pkg::*;
#(
  parameter int RST_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          phy_link_ok,
  input  logic          phy_speed_10,
  input  logic          phy_duplex,
  input  logic          rx_overflow,
  input  logic          wake_event,
  input  logic          tx_done_slot1,
  input  logic          tx_done_slot2,
  input  logic          tx_done,
  output logic          sw_reset_o,
  output logic [1:0]    loopback_mode,
  output logic          force_col,
  output logic          full_duplex,
  output logic          ext_phy_sel,
  output logic          wake_en,
  output logic          tx_req,
  output logic          crc_dis_slot1,
  output logic          pad_dis_slot1,
  output logic          crc_dis_slot2,
  output logic          pad_dis_slot2,
  output logic          excol_retry,
  output logic          jabber_dis
);
  // host decode
  logic wr, rd, wr_ctrl, wr_stat, wr_txc, rd_stat;
  assign wr      = host_cs &  host_we;
  assign rd      = host_cs & ~host_we;
  assign wr_ctrl = wr && (host_addr == A_CTRL);
  assign wr_stat = wr && (host_addr == A_STAT);
  assign wr_txc  = wr && (host_addr == A_TXC);
  assign rd_stat = rd && (host_addr == A_STAT);

  // software reset sequencing
  logic rst_busy, rst_start, hold;
  assign rst_start = wr_ctrl & host_wdata[C_SWRST] & ~rst_busy;
  assign hold      = rst_busy | rst_start;

  emac_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .busy  (rst_busy)
  );

  // control register: preserved bits
  logic ext_q, wen_q, ext_nxt, wen_nxt;
  assign ext_nxt = wr_ctrl ? host_wdata[C_EXT] : ext_q;
  assign wen_nxt = wr_ctrl ? host_wdata[C_WEN] : wen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      wen_q <= 1'b0;
    end else begin
      ext_q <= ext_nxt;
      wen_q <= wen_nxt;
    end
  end

  // control register: bits cleared by software reset
  logic [1:0] lb_q;
  logic       fcol_q, fdx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      lb_q   <= 2'b00;
      fcol_q <= 1'b0;
      fdx_q  <= 1'b0;
    end else if (wr_ctrl) begin
      lb_q   <= host_wdata[C_LB_HI:C_LB_LO];
      fcol_q <= host_wdata[C_FCOL];
      if (ext_nxt) fdx_q <= host_wdata[C_FDX];
    end
  end

  // transmit control register
  logic [T_CFG_W-1:0] txcfg_q;
  logic               txreq_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      txcfg_q <= '0;
      txreq_q <= 1'b0;
    end else begin
      if (wr_txc) txcfg_q <= host_wdata[T_CFG_HI:T_CFG_LO];
      if (wr_txc && host_wdata[T_REQ]) txreq_q <= 1'b1;
      else if (tx_done)                txreq_q <= 1'b0;
    end
  end

  // sticky status flags
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic [NFLAG-1:0] flag_w1c;

  assign flag_w1c[F_TX1]  = host_wdata[S_TX1];
  assign flag_w1c[F_TX2]  = host_wdata[S_TX2];
  assign flag_w1c[F_WAKE] = host_wdata[S_WAKE];

  assign flag_set[F_TX1]  = tx_done_slot1 & ~hold;
  assign flag_set[F_TX2]  = tx_done_slot2 & ~hold;
  assign flag_set[F_WAKE] = wake_event & wen_nxt;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic extra_clr;
    if (g == F_WAKE) begin : g_pres
      assign extra_clr = ~wen_nxt;
    end else begin : g_nonpres
      assign extra_clr = hold;
    end
    assign flag_clr[g] = extra_clr | rd_stat | (wr_stat & flag_w1c[g]);

    emac_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (flag_clr[g]),
      .q     (flag_q[g])
    );
  end

  // outputs
  assign sw_reset_o    = rst_busy;
  assign loopback_mode = lb_q;
  assign force_col     = fcol_q;
  assign full_duplex   = ext_q ? fdx_q : phy_duplex;
  assign ext_phy_sel   = ext_q;
  assign wake_en       = wen_q;
  assign tx_req        = txreq_q;
  assign crc_dis_slot1 = txcfg_q[0];
  assign pad_dis_slot1 = txcfg_q[1];
  assign crc_dis_slot2 = txcfg_q[2];
  assign pad_dis_slot2 = txcfg_q[3];
  assign excol_retry   = txcfg_q[4];
  assign jabber_dis    = txcfg_q[5];

  // read mux
  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL: begin
        host_rdata[C_SWRST]         = rst_busy;
        host_rdata[C_FDX]           = full_duplex;
        host_rdata[C_LB_HI:C_LB_LO] = lb_q;
        host_rdata[C_EXT]           = ext_q;
        host_rdata[C_WEN]           = wen_q;
        host_rdata[C_FCOL]          = fcol_q;
      end
      A_STAT: begin
        host_rdata[S_LINK] = phy_link_ok;
        host_rdata[S_SPD]  = phy_speed_10;
        host_rdata[S_OVF]  = rx_overflow;
        host_rdata[S_TX1]  = flag_q[F_TX1];
        host_rdata[S_TX2]  = flag_q[F_TX2];
        host_rdata[S_WAKE] = flag_q[F_WAKE];
      end
      A_TXC: begin
        host_rdata[T_REQ]             = txreq_q;
        host_rdata[T_CFG_HI:T_CFG_LO] = txcfg_q;
      end
      default: host_rdata = '0;
    endcase
  end

  // assertions
  p_hold_defaults_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (loopback_mode == 2'b00) && !force_col && !tx_req &&
                 !crc_dis_slot1 && !pad_dis_slot1 && !crc_dis_slot2 &&
                 !pad_dis_slot2 && !excol_retry && !jabber_dis);
  p_wake_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en && !(wr_ctrl && host_wdata[C_WEN])) |=> !host_flag_wake());
  p_txreq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(wr_txc && host_wdata[T_REQ])) |=> !tx_req);
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata[DW-1]);
  p_preserve_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && !wr_ctrl) |=> ext_phy_sel == $past(ext_phy_sel) && wake_en == $past(wake_en));

  function automatic logic host_flag_wake();
    return flag_q[F_WAKE];
  endfunction
endmodule

// File: tb/test_emac_regbank.sv
module test_emac_regbank;
  localparam int RSTC = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, host_cs, host_we;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic phy_link_ok, phy_speed_10, phy_duplex, rx_overflow, wake_event;
  logic tx_done_slot1, tx_done_slot2, tx_done;
  logic sw_reset_o, force_col, full_duplex, ext_phy_sel, wake_en, tx_req;
  logic [1:0] loopback_mode;
  logic crc_dis_slot1, pad_dis_slot1, crc_dis_slot2, pad_dis_slot2, excol_retry, jabber_dis;

  emac_regbank #(.RST_CYCLES(RSTC)) i_emac_regbank (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phy_link_ok(phy_link_ok), .phy_speed_10(phy_speed_10), .phy_duplex(phy_duplex),
    .rx_overflow(rx_overflow), .wake_event(wake_event),
    .tx_done_slot1(tx_done_slot1), .tx_done_slot2(tx_done_slot2), .tx_done(tx_done),
    .sw_reset_o(sw_reset_o), .loopback_mode(loopback_mode), .force_col(force_col),
    .full_duplex(full_duplex), .ext_phy_sel(ext_phy_sel), .wake_en(wake_en),
    .tx_req(tx_req), .crc_dis_slot1(crc_dis_slot1), .pad_dis_slot1(pad_dis_slot1),
    .crc_dis_slot2(crc_dis_slot2), .pad_dis_slot2(pad_dis_slot2),
    .excol_retry(excol_retry), .jabber_dis(jabber_dis)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  item_t exp_q[$];
  logic [7:0] obs_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // monitor: pops expected and observed items and compares them
  always @(negedge clk) begin
    while (exp_q.size() != 0 && obs_q.size() != 0) begin
      item_t e;
      logic [7:0] a;
      e = exp_q.pop_front();
      a = obs_q.pop_front();
      checks++;
      if (a !== e.val) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", e.req, a, e.val);
      end
    end
  end

  task automatic expect_val(input string req, input logic [7:0] act, input logic [7:0] exp);
    exp_q.push_back('{req: req, val: exp});
    obs_q.push_back(act);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    #1;
    expect_val(req, host_rdata, exp);
    @(negedge clk);
    host_cs = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: wake_event = 1'b1;
      1: tx_done_slot1 = 1'b1;
      2: tx_done_slot2 = 1'b1;
      default: tx_done = 1'b1;
    endcase
    @(negedge clk);
    wake_event = 1'b0; tx_done_slot1 = 1'b0; tx_done_slot2 = 1'b0; tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_cs = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    phy_link_ok = 1'b0; phy_speed_10 = 1'b0; phy_duplex = 1'b0; rx_overflow = 1'b0;
    wake_event = 1'b0; tx_done_slot1 = 1'b0; tx_done_slot2 = 1'b0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 stat");
    rd(2'd2, 8'h00, "R1 txc");
    expect_val("R1 outputs", {sw_reset_o, loopback_mode, force_col, full_duplex, ext_phy_sel, wake_en, tx_req}, 8'h00);

    // R2 read-only level bits
    @(negedge clk); phy_link_ok = 1'b1; phy_speed_10 = 1'b1; rx_overflow = 1'b1;
    rd(2'd1, 8'h07, "R2 levels");
    wr(2'd1, 8'hC7);
    rd(2'd1, 8'h07, "R2 write ignored");

    // R3 sticky, clear on read
    pulse(1);
    rd(2'd1, 8'h0F, "R3 tx1 set");
    rd(2'd1, 8'h07, "R3 cleared by read");

    // R4 write-one-to-clear per bit
    pulse(1); pulse(2);
    wr(2'd1, 8'h08);
    rd(2'd1, 8'h17, "R4 w1c tx1 only");

    // R5 event beats clear
    @(negedge clk);
    tx_done_slot1 = 1'b1; host_cs = 1'b1; host_we = 1'b1; host_addr = 2'd1; host_wdata = 8'h08;
    @(negedge clk);
    tx_done_slot1 = 1'b0; host_cs = 1'b0; host_we = 1'b0;
    rd(2'd1, 8'h0F, "R5 event wins");

    // R6 wakeup gating and clear by disable
    pulse(0);
    rd(2'd1, 8'h07, "R6 no wake while disabled");
    wr(2'd0, 8'h20);
    pulse(0);
    rd(2'd1, 8'h27, "R6 wake set");
    pulse(0);
    wr(2'd0, 8'h00);
    rd(2'd1, 8'h07, "R6 disable clears wake");

    // R7 loopback and force collision
    wr(2'd0, 8'h4C);
    rd(2'd0, 8'h4C, "R7 ctrl readback");
    expect_val("R7 outputs", {5'b0, loopback_mode, force_col}, 8'h07);
    wr(2'd0, 8'h08);
    expect_val("R7 reserved code", {6'b0, loopback_mode}, 8'h02);

    // R8 duplex follows PHY select
    wr(2'd0, 8'h02);
    rd(2'd0, 8'h00, "R8 internal phy ignores write");
    @(negedge clk); phy_duplex = 1'b1;
    rd(2'd0, 8'h02, "R8 internal phy duplex");
    expect_val("R8 duplex pin", {7'b0, full_duplex}, 8'h01);
    @(negedge clk); phy_duplex = 1'b0;
    wr(2'd0, 8'h12);
    rd(2'd0, 8'h12, "R8 external phy writable");
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h10, "R8 external phy cleared");

    // R9 reserved bits and unused address
    wr(2'd0, 8'h90);
    rd(2'd0, 8'h10, "R9 ctrl bit7");
    wr(2'd2, 8'h80);
    rd(2'd2, 8'h00, "R9 txc bit7");
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R9 address 3");
    rd(2'd0, 8'h10, "R9 address 3 write no effect");

    // R10 transmit config fields
    wr(2'd2, 8'h7E);
    rd(2'd2, 8'h7E, "R10 txc readback");
    expect_val("R10 pins", {2'b0, jabber_dis, excol_retry, pad_dis_slot2, crc_dis_slot2, pad_dis_slot1, crc_dis_slot1}, 8'h3F);
    wr(2'd2, 8'h0A);
    expect_val("R10 pins pattern", {2'b0, jabber_dis, excol_retry, pad_dis_slot2, crc_dis_slot2, pad_dis_slot1, crc_dis_slot1}, 8'h05);

    // R11 transmit request
    wr(2'd2, 8'h7F);
    expect_val("R11 req set", {7'b0, tx_req}, 8'h01);
    wr(2'd2, 8'h7E);
    rd(2'd2, 8'h7F, "R11 write 0 ignored");
    pulse(3);
    rd(2'd2, 8'h7E, "R11 cleared by tx_done");

    // R12 / R13 software reset
    wr(2'd0, 8'h36);
    rd(2'd0, 8'h36, "R13 setup ctrl");
    pulse(0); pulse(1);
    wr(2'd0, 8'h37);
    expect_val("R12 busy pin", {7'b0, sw_reset_o}, 8'h01);
    rd(2'd0, 8'h31, "R12 R13 ctrl during reset");
    rd(2'd2, 8'h00, "R13 txc during reset");
    wr(2'd2, 8'h7E);
    wr(2'd0, 8'h3D);
    expect_val("R13 writes ignored", {1'b0, jabber_dis, loopback_mode, crc_dis_slot1, tx_req, force_col, 1'b0}, 8'h00);
    repeat (RSTC + 8) @(negedge clk);
    #1;
    expect_val("R12 busy ends", {7'b0, sw_reset_o}, 8'h00);
    rd(2'd0, 8'h30, "R12 ctrl after reset");
    rd(2'd1, 8'h27, "R13 wake kept tx1 cleared");
    rd(2'd2, 8'h00, "R13 txc after reset");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule